// File: doc/BRIEF.md
# Dual-Pool Receive Byte Buffer

This block sits between a serial receive path and a microcontroller. Received frame bytes come in one per write strobe, and a marker on the last byte ends the frame. The bytes are stored in two alternating pools of `POOL_DEPTH` bytes each. Each pool that fills up is handed to the host with a pool-full interrupt. The last, partial or full, block of a frame is handed over with a message-end interrupt. The host then reads the block in arrival order, one byte per read strobe, and frees the pool with an acknowledge pulse. A long frame therefore arrives as a run of full blocks followed by one remainder block of 1 to `POOL_DEPTH` bytes.

While one block waits for acknowledgement, reception goes on in the other pool. If that pool would also complete before the host acknowledges, the block records a receive overflow. It then discards incoming bytes until the acknowledge. A frame byte counter of `CNT_W` bits counts the accepted bytes of the current frame. It raises a sticky frame-length overflow flag when it wraps, and it keeps counting after the wrap.

Top module: `rx_pool_fifo`

## Requirements
- R1: After reset, both interrupts, `blk_len`, `frame_cnt`, `frame_ovf`, `rx_ovf` and `rd_data` are zero.
- R2: A written byte that fills a pool and has `wr_eof`=0 raises `irq_pool_full` in the following cycle, with `blk_len` = `POOL_DEPTH`. No interrupt is raised at the other byte positions of a block.
- R3: A written byte with `wr_eof`=1 raises `irq_msg_end` in the following cycle. `blk_len` then equals the number of bytes written since the last full block, a value from 1 to `POOL_DEPTH`.
- R4: Each `rd_en` pulse on a pending block presents the next byte of that block, in write order, on `rd_data` in the cycle after the pulse. The value is held until the next `rd_en`.
- R5: An `rd_en` pulse that comes after `blk_len` bytes have been read, or while no interrupt is pending, makes `rd_data` zero and does not advance the read position.
- R6: A pending interrupt, its `blk_len` and its pool contents stay unchanged until `ack`. After `ack` the interrupt is low, and the next block is read from its first byte.
- R7: While a block is pending, bytes that do not complete the other pool are accepted and are delivered intact as part of the next block.
- R8: A byte that would complete the write pool while an earlier interrupt is still unacknowledged is dropped and sets `rx_ovf`. All later bytes are also dropped until `ack`. That `ack` clears `rx_ovf`, discards the partly filled pool and starts a new frame count.
- R9: `frame_cnt` counts the accepted bytes of the current frame. It keeps its value after the end-of-frame byte, and the first byte of the next frame loads it with 1.
- R10: When an accepted byte moves `frame_cnt` past 2^`CNT_W`-1, `frame_ovf` is set and the counter wraps to 0 and keeps counting. `frame_ovf` stays set until the first byte of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe from the receive path |
| wr_data | input | DATA_W | Received byte |
| wr_eof | input | 1 | Marks the written byte as the last byte of its frame |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | DATA_W | Byte read from the pending block, zero when out of range |
| ack | input | 1 | Host acknowledge; releases the pending block |
| irq_pool_full | output | 1 | A full pool is pending |
| irq_msg_end | output | 1 | The last block of a frame is pending |
| blk_len | output | $clog2(POOL_DEPTH)+1 | Byte count of the pending block, 0 when none |
| frame_cnt | output | CNT_W | Accepted bytes of the current frame |
| frame_ovf | output | 1 | Frame length passed the counter range |
| rx_ovf | output | 1 | A block was lost because the host did not acknowledge in time |

## Verification
The bench builds the block with `POOL_DEPTH`=4 and `CNT_W`=5. With these values every frame length from 1 to 40 bytes can be swept with few cycles. The sweep covers every remainder length, single-block and multi-block frames, and counter wrap at exactly 32 bytes as well as past it. A small pool also makes it cheap to fill the second pool while the first is still unacknowledged, so both the accepted-during-wait path and the overflow-drop path are driven directly.

// File: rtl/rx_pool_pkg.sv
package rx_pool_pkg;
  typedef enum logic {
    KIND_FULL = 1'b0,
    KIND_END  = 1'b1
  } blk_kind_e;
endpackage

// File: rtl/rx_pool_mem.sv
// Two pools in one simple dual-port array; registered read for block RAM.
module rx_pool_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int AW    = $clog2(2 * DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [2*DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/rx_frame_counter.sv
// Per-frame byte counter: wraps, flags the wrap, keeps counting.
module rx_frame_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             eof,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  logic new_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      ovf       <= 1'b0;
      new_frame <= 1'b1;
    end else if (inc) begin
      if (new_frame) begin
        cnt <= CNT_W'(1);
        ovf <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == '1) ovf <= 1'b1;
      end
      new_frame <= eof;
    end else if (restart) begin
      new_frame <= 1'b1;
    end
  end

  p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
    inc && !new_frame && (cnt == '1) |=> (cnt == '0) && ovf);
  p_ovf_keep_r10: assert property (@(posedge clk) disable iff (rst)
    ovf && !(inc && new_frame) |=> ovf);
endmodule

// File: rtl/rx_pool_ctrl.sv
// Write side and handoff: pool alternation, pending block, overflow drop.
module rx_pool_ctrl
  import rx_pool_pkg::*;
#(
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_eof,
  input  logic             ack,
  output logic             accept,
  output logic [IDX_W:0]   waddr,
  output logic             restart,
  output logic             pend,
  output blk_kind_e        kind,
  output logic             hpool,
  output logic [LEN_W-1:0] hlen,
  output logic             rx_ovf
);
  logic             wpool;
  logic [IDX_W-1:0] wcnt;
  logic             completes;
  logic             busy_after;
  logic             ovf_hit;

  assign completes  = wr_eof || (wcnt == IDX_W'(DEPTH - 1));
  assign busy_after = pend && !ack;
  assign accept     = wr_en && !rx_ovf && !(completes && busy_after);
  assign ovf_hit    = wr_en && !rx_ovf && completes && busy_after;
  assign restart    = ack && rx_ovf;
  assign waddr      = {wpool, wcnt};

  always_ff @(posedge clk) begin
    if (rst) begin
      wpool  <= 1'b0;
      wcnt   <= '0;
      pend   <= 1'b0;
      kind   <= KIND_FULL;
      hpool  <= 1'b0;
      hlen   <= '0;
      rx_ovf <= 1'b0;
    end else begin
      if (ack) pend <= 1'b0;
      if (restart) begin
        rx_ovf <= 1'b0;
        wcnt   <= '0;
      end else if (ovf_hit) begin
        rx_ovf <= 1'b1;
      end
      if (accept) begin
        if (completes) begin
          pend  <= 1'b1;
          kind  <= wr_eof ? KIND_END : KIND_FULL;
          hpool <= wpool;
          hlen  <= LEN_W'(wcnt) + 1'b1;
          wpool <= ~wpool;
          wcnt  <= '0;
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  p_full_len_r2: assert property (@(posedge clk) disable iff (rst)
    pend && (kind == KIND_FULL) |-> hlen == LEN_W'(DEPTH));
  p_len_range_r3: assert property (@(posedge clk) disable iff (rst)
    pend |-> (hlen != '0) && (hlen <= LEN_W'(DEPTH)));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    pend && !ack |=> pend && $stable(hpool) && $stable(hlen) && $stable(kind));
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    rx_ovf && !ack |=> rx_ovf && $stable(wcnt));
endmodule

// File: rtl/rx_pool_fifo.sv
module rx_pool_fifo
  import rx_pool_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POOL_DEPTH = 32,
  parameter int CNT_W      = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          wr_eof,
  input  logic                          rd_en,
  output logic [DATA_W-1:0]             rd_data,
  input  logic                          ack,
  output logic                          irq_pool_full,
  output logic                          irq_msg_end,
  output logic [$clog2(POOL_DEPTH):0]   blk_len,
  output logic [CNT_W-1:0]              frame_cnt,
  output logic                          frame_ovf,
  output logic                          rx_ovf
);
  localparam int IDX_W = $clog2(POOL_DEPTH);
  localparam int LEN_W = IDX_W + 1;

  logic             accept;
  logic [IDX_W:0]   waddr;
  logic             restart;
  logic             pend;
  blk_kind_e        kind;
  logic             hpool;
  logic [LEN_W-1:0] hlen;
  logic [LEN_W-1:0] rptr;
  logic             rd_valid;
  logic             rd_hit;
  logic [DATA_W-1:0] mem_q;

  rx_pool_ctrl #(.DEPTH(POOL_DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_eof(wr_eof), .ack(ack),
    .accept(accept), .waddr(waddr), .restart(restart), .pend(pend),
    .kind(kind), .hpool(hpool), .hlen(hlen), .rx_ovf(rx_ovf)
  );

  rx_frame_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(accept), .eof(wr_eof), .restart(restart),
    .cnt(frame_cnt), .ovf(frame_ovf)
  );

  rx_pool_mem #(.DATA_W(DATA_W), .DEPTH(POOL_DEPTH)) u_mem (
    .clk(clk), .we(accept), .waddr(waddr), .wdata(wr_data),
    .re(rd_hit), .raddr({hpool, rptr[IDX_W-1:0]}), .rdata(mem_q)
  );

  assign rd_hit = rd_en && !ack && pend && (rptr < hlen);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr     <= '0;
      rd_valid <= 1'b0;
    end else if (ack) begin
      rptr <= '0;
      if (rd_en) rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= rd_hit;
      if (rd_hit) rptr <= rptr + 1'b1;
    end
  end

  assign rd_data       = rd_valid ? mem_q : '0;
  assign irq_pool_full = pend && (kind == KIND_FULL);
  assign irq_msg_end   = pend && (kind == KIND_END);
  assign blk_len       = pend ? hlen : '0;

  p_rd_zero_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en && !pend |=> rd_data == '0);
  p_rptr_bound_r5: assert property (@(posedge clk) disable iff (rst)
    pend |-> rptr <= hlen);
endmodule

// File: tb/rx_pool_fifo_test.sv
module rx_pool_fifo_test;
  localparam int D = 4;
  localparam int C = 5;
  localparam int LW = $clog2(D) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, wr_eof = 1'b0, rd_en = 1'b0, ack = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_pool_full, irq_msg_end, frame_ovf, rx_ovf;
  logic [LW-1:0] blk_len;
  logic [C-1:0] frame_cnt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rx_pool_fifo #(.DATA_W(8), .POOL_DEPTH(D), .CNT_W(C)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof),
    .rd_en(rd_en), .rd_data(rd_data), .ack(ack),
    .irq_pool_full(irq_pool_full), .irq_msg_end(irq_msg_end),
    .blk_len(blk_len), .frame_cnt(frame_cnt), .frame_ovf(frame_ovf),
    .rx_ovf(rx_ovf)
  );

  function automatic logic [7:0] byte_of(int f, int i);
    return 8'((f * 37 + i * 11 + 1) & 255);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d, logic e);
    wr_en = 1'b1; wr_data = d; wr_eof = e;
    @(negedge clk);
    wr_en = 1'b0; wr_eof = 1'b0;
  endtask

  task automatic rd();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk("R6", "irq after ack", int'(irq_pool_full | irq_msg_end), 0);
  endtask

  // read n bytes of frame f starting after byte index base, then one extra
  task automatic drain(int f, int base, int n);
    for (int k = 1; k <= n; k++) begin
      rd();
      chk("R4", "read byte", int'(rd_data), int'(byte_of(f, base + k)));
    end
    rd();
    chk("R5", "read past block", int'(rd_data), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "pool_full", int'(irq_pool_full), 0);
    chk("R1", "msg_end", int'(irq_msg_end), 0);
    chk("R1", "blk_len", int'(blk_len), 0);
    chk("R1", "frame_cnt", int'(frame_cnt), 0);
    chk("R1", "frame_ovf", int'(frame_ovf), 0);
    chk("R1", "rx_ovf", int'(rx_ovf), 0);
    chk("R1", "rd_data", int'(rd_data), 0);
    rd();
    chk("R5", "read idle", int'(rd_data), 0);

    // Sweep of frame lengths: R2 R3 R9 R10
    for (int L = 1; L <= 40; L++) begin
      int base;
      base = 0;
      for (int i = 1; i <= L; i++) begin
        wr(byte_of(L, i), i == L);
        if (i == L) begin
          chk("R3", "msg_end", int'(irq_msg_end), 1);
          chk("R3", "pool_full at end", int'(irq_pool_full), 0);
          chk("R3", "remainder len", int'(blk_len), i - base);
          chk("R9", "frame_cnt", int'(frame_cnt), L % 32);
          chk("R10", "frame_ovf", int'(frame_ovf), int'(L >= 32));
          drain(L, base, i - base);
          do_ack();
        end else if (i - base == D) begin
          chk("R2", "pool_full", int'(irq_pool_full), 1);
          chk("R2", "full len", int'(blk_len), D);
          drain(L, base, D);
          do_ack();
          base = i;
        end else begin
          chk("R2", "no irq mid block", int'(irq_pool_full | irq_msg_end), 0);
        end
      end
    end

    // R7: other pool keeps filling while a block waits; R6 hold
    for (int i = 1; i <= 7; i++) wr(byte_of(100, i), 1'b0);
    repeat (3) @(negedge clk);
    chk("R6", "pool_full held", int'(irq_pool_full), 1);
    chk("R6", "len held", int'(blk_len), D);
    chk("R9", "count while waiting", int'(frame_cnt), 7);
    chk("R10", "ovf cleared new frame", int'(frame_ovf), 0);
    chk("R8", "no rx_ovf", int'(rx_ovf), 0);
    drain(100, 0, D);
    do_ack();
    wr(byte_of(100, 8), 1'b1);
    chk("R7", "msg_end", int'(irq_msg_end), 1);
    chk("R7", "len", int'(blk_len), 4);
    drain(100, 4, 4);
    chk("R9", "frame_cnt", int'(frame_cnt), 8);
    do_ack();

    // R8: completing a block while one is unacknowledged
    for (int i = 1; i <= 7; i++) wr(byte_of(101, i), 1'b0);
    chk("R8", "rx_ovf before", int'(rx_ovf), 0);
    wr(byte_of(101, 8), 1'b0);
    chk("R8", "rx_ovf set", int'(rx_ovf), 1);
    chk("R8", "first irq kept", int'(irq_pool_full), 1);
    wr(byte_of(101, 9), 1'b0);
    wr(byte_of(101, 10), 1'b1);
    chk("R8", "dropped bytes not counted", int'(frame_cnt), 7);
    chk("R8", "no msg_end from dropped eof", int'(irq_msg_end), 0);
    do_ack();
    chk("R8", "rx_ovf cleared", int'(rx_ovf), 0);
    wr(byte_of(102, 1), 1'b0);
    wr(byte_of(102, 2), 1'b1);
    chk("R8", "partial discarded", int'(blk_len), 2);
    chk("R8", "new frame count", int'(frame_cnt), 2);
    drain(102, 0, 2);
    do_ack();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule